// File: doc/BRIEF.md
# Page-Mode Asynchronous DRAM Controller

This block sits between a simple word request port and an asynchronous DRAM whose row and column addresses share one set of address pins. Each accepted request becomes a strobe sequence on active-low row strobe, column strobe, write enable and output enable lines. The row address is presented when the row strobe falls, and the column address when the column strobe falls. Read data is captured once both the row-access and column-access minimums have elapsed.

After an access the row is left open, with the row strobe held low. A later request to the same row is served with a column-only cycle, which is much shorter than a full row cycle. A request to a different row first closes the open row. It then waits out the precharge and row-cycle minimums before opening the new row.

A refresh timer requests a row-strobe-only cycle at a fixed interval, and each refresh steps a refresh row counter. A pending refresh blocks new requests, closes any open row and runs as soon as the row timing allows. Every timing limit is a nanosecond parameter. Each is turned into a clock-cycle count by ceiling division by the clock period.

Top module: `fpdram_ctrl`

## Requirements
- R1: After reset all four strobes (ras_n, cas_n, we_n, oe_n) are high, dram_dq_oe and rsp_valid are low, and req_ready is high.
- R2: A byte written to an address is returned by a later read of that address; write data is driven on dram_dq_out with dram_dq_oe high while the column strobe is low.
- R3: The default timing is a 4 ns clock, a 60 ns row access, a 15 ns column access, a 110 ns row cycle, a 35 ns page cycle and a 40 ns precharge. These give 15, 4, 28, 9 and 10 cycles. When no row is open, the row strobe falls at the accept edge with req_addr[17:9] on dram_addr. The column strobe falls 11 cycles later with req_addr[8:0] on dram_addr. rsp_valid rises 15 cycles after the accept edge.
- R4: A request whose row equals the open row produces no new row strobe fall. For a read, rsp_valid rises 5 cycles after the accept edge.
- R5: A request to another row raises the row strobe before the new row opens. Row strobe falls are at least 28 cycles apart, and the row strobe stays high at least 10 cycles between row accesses.
- R6: Column strobe falls are at least 9 cycles apart, and back-to-back page reads achieve exactly 9.
- R7: With the default early output enable, oe_n is low in the cycle before the column strobe falls for a read. For a write, oe_n stays high while we_n and dram_dq_oe are low and high.
- R8: Every 3900 cycles (15.6 us) a refresh takes place: the row strobe is low for 15 cycles with the column strobe high. The refresh row on dram_addr rises by one on each refresh.
- R9: A pending refresh closes an open row, so the next access to that row is a full row access with the 15-cycle latency.
- R10: The column strobe is low only while the row strobe is low, we_n and oe_n are never low together, and rsp_valid pulses exactly once per read and never for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address, row in upper 9 bits, column in lower 9 |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Request accepted on this edge when req_valid is high |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 8 | Read byte |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 8 | Data to the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 8 | Data from the DRAM |

## Verification
The checker watches every cycle for these rules: row strobe falls at least a row cycle apart, column strobe falls at least a page cycle apart, the column strobe only inside an open row, no overlap of write and output enables, and read strobes only at a column strobe release. Data integrity, the exact latencies of row and page accesses, the absence of a row reopen on a page hit, the refresh row sequence, and the row closing forced by refresh can only be shown by the bench scenarios. The bench does this against its behavioural memory model.

// File: rtl/fpdram_pkg.sv
package fpdram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RCD,
      ST_COL,
      ST_CAS,
      ST_OPEN,
      ST_REF
   } ctl_state_t;

   function automatic int ns_to_cyc(input int ns, input int clk_ns);
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

endpackage

// File: rtl/fpdram_since.sv
module fpdram_since #(
   parameter int LIMIT = 8,
   localparam int W = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   output logic reached
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= W'(LIMIT);
      else if (clear)
         cnt <= '0;
      else if (cnt != W'(LIMIT))
         cnt <= cnt + 1'b1;
   end

   assign reached = (cnt == W'(LIMIT));
endmodule

// File: rtl/fpdram_refresh.sv
module fpdram_refresh #(
   parameter int PERIOD = 3900,
   parameter int ROW_W  = 9,
   localparam int TW = $clog2(PERIOD)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ack,
   output logic             pend,
   output logic [ROW_W-1:0] row
);
   logic [TW-1:0] tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick <= '0;
         pend <= 1'b0;
         row  <= '0;
      end else begin
         if (tick == TW'(PERIOD - 1)) begin
            tick <= '0;
            pend <= 1'b1;
         end else begin
            tick <= tick + 1'b1;
            if (ack) pend <= 1'b0;
         end
         if (ack) row <= row + 1'b1;
      end
   end
endmodule

// File: rtl/fpdram_ctrl.sv
module fpdram_ctrl
   import fpdram_pkg::*;
#(
   parameter int CLK_NS    = 4,
   parameter int T_RAC_NS  = 60,
   parameter int T_CAC_NS  = 15,
   parameter int T_RC_NS   = 110,
   parameter int T_PC_NS   = 35,
   parameter int T_RP_NS   = 40,
   parameter int T_REFI_NS = 15600,
   parameter int ROW_W     = 9,
   parameter int COL_W     = 9,
   parameter int DATA_W    = 8,
   parameter bit LATE_OE   = 1'b0,
   localparam int ADDR_W   = ROW_W + COL_W,
   localparam int MUX_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [MUX_W-1:0]  dram_addr,
   output logic              dram_ras_n,
   output logic              dram_cas_n,
   output logic              dram_we_n,
   output logic              dram_oe_n,
   output logic [DATA_W-1:0] dram_dq_out,
   output logic              dram_dq_oe,
   input  logic [DATA_W-1:0] dram_dq_in
);
   localparam int RAC_C  = ns_to_cyc(T_RAC_NS, CLK_NS);
   localparam int CAC_C  = ns_to_cyc(T_CAC_NS, CLK_NS);
   localparam int RC_C   = ns_to_cyc(T_RC_NS, CLK_NS);
   localparam int PC_C   = ns_to_cyc(T_PC_NS, CLK_NS);
   localparam int RP_C   = ns_to_cyc(T_RP_NS, CLK_NS);
   localparam int REFI_C = ns_to_cyc(T_REFI_NS, CLK_NS);
   localparam int RCD_C  = RAC_C - CAC_C;
   localparam int CNT_W  = $clog2(RAC_C + 1);
   localparam int LIM [3] = '{RC_C - 1, PC_C - 2, RP_C - 1};

   if (RCD_C < 2 || CAC_C < 2 || PC_C < CAC_C + 2 || RP_C < 2 || REFI_C < 2 * RC_C)
      $error("fpdram_ctrl: timing parameters out of range");
   if (ROW_W < 1 || COL_W < 1 || DATA_W < 1)
      $error("fpdram_ctrl: width parameters out of range");

   ctl_state_t        st;
   logic [CNT_W-1:0]  cnt;
   logic              wr_q;
   logic [COL_W-1:0]  col_q;
   logic [DATA_W-1:0] wd_q;
   logic [ROW_W-1:0]  open_row_q;

   logic              ref_pend;
   logic [ROW_W-1:0]  ref_row;
   logic [2:0]        clr, ok;
   logic              rc_ok, pc_ok, rp_ok;

   wire [ROW_W-1:0] req_row = req_addr[ADDR_W-1:COL_W];
   wire [COL_W-1:0] req_col = req_addr[COL_W-1:0];
   wire             row_hit = (req_row == open_row_q);

   assign rc_ok = ok[0];
   assign pc_ok = ok[1];
   assign rp_ok = ok[2];

   wire start_ref = (st == ST_IDLE) && ref_pend && rc_ok && rp_ok;
   wire acc_idle  = (st == ST_IDLE) && !ref_pend && rc_ok && rp_ok;
   wire acc_page  = (st == ST_OPEN) && !ref_pend && row_hit && pc_ok;
   assign req_ready = acc_idle | acc_page;
   wire take      = req_valid & req_ready;

   wire page_go   = take & acc_page;
   wire go_col    = ((st == ST_RCD) && (cnt == CNT_W'(RCD_C - 2))) || page_go;
   wire col_wr    = page_go ? req_write : wr_q;
   wire done_cas  = (st == ST_CAS) && (cnt == CNT_W'(CAC_C - 1));
   wire close_row = ((st == ST_OPEN) && (ref_pend || (req_valid && !row_hit))) ||
                    ((st == ST_REF) && (cnt == CNT_W'(RAC_C - 1)));

   // timing windows: row cycle, page cycle, precharge
   assign clr[0] = start_ref | (take & acc_idle);
   assign clr[1] = (st == ST_COL);
   assign clr[2] = close_row;

   for (genvar g = 0; g < 3; g++) begin : g_win
      fpdram_since #(.LIMIT(LIM[g])) u_win (
         .clk     (clk),
         .rst_n   (rst_n),
         .clear   (clr[g]),
         .reached (ok[g])
      );
   end

   fpdram_refresh #(.PERIOD(REFI_C), .ROW_W(ROW_W)) u_ref (
      .clk   (clk),
      .rst_n (rst_n),
      .ack   (start_ref),
      .pend  (ref_pend),
      .row   (ref_row)
   );

   logic oe_fall;
   if (LATE_OE) begin : g_oe_late
      assign oe_fall = (st == ST_CAS) && (cnt == '0) && !wr_q;
   end else begin : g_oe_early
      assign oe_fall = go_col && !col_wr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         cnt         <= '0;
         wr_q        <= 1'b0;
         col_q       <= '0;
         wd_q        <= '0;
         open_row_q  <= '0;
         rsp_valid   <= 1'b0;
         rsp_rdata   <= '0;
         dram_addr   <= '0;
         dram_ras_n  <= 1'b1;
         dram_cas_n  <= 1'b1;
         dram_we_n   <= 1'b1;
         dram_oe_n   <= 1'b1;
         dram_dq_out <= '0;
         dram_dq_oe  <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         cnt       <= cnt + 1'b1;
         if (oe_fall) dram_oe_n <= 1'b0;
         if (go_col) begin
            st          <= ST_COL;
            dram_we_n   <= !col_wr;
            dram_dq_oe  <= col_wr;
            dram_dq_out <= page_go ? req_wdata : wd_q;
            dram_addr   <= MUX_W'(page_go ? req_col : col_q);
            if (page_go) begin
               wr_q  <= req_write;
               col_q <= req_col;
               wd_q  <= req_wdata;
            end
         end
         case (st)
            ST_IDLE: begin
               if (start_ref) begin
                  st         <= ST_REF;
                  cnt        <= '0;
                  dram_ras_n <= 1'b0;
                  dram_addr  <= MUX_W'(ref_row);
               end else if (take) begin
                  st         <= ST_RCD;
                  cnt        <= '0;
                  dram_ras_n <= 1'b0;
                  dram_addr  <= MUX_W'(req_row);
                  open_row_q <= req_row;
                  wr_q       <= req_write;
                  col_q      <= req_col;
                  wd_q       <= req_wdata;
               end
            end
            ST_COL: begin
               st         <= ST_CAS;
               cnt        <= '0;
               dram_cas_n <= 1'b0;
            end
            ST_CAS: begin
               if (done_cas) begin
                  st         <= ST_OPEN;
                  dram_cas_n <= 1'b1;
                  dram_oe_n  <= 1'b1;
                  dram_we_n  <= 1'b1;
                  dram_dq_oe <= 1'b0;
                  if (!wr_q) begin
                     rsp_valid <= 1'b1;
                     rsp_rdata <= dram_dq_in;
                  end
               end
            end
            ST_OPEN, ST_REF: begin
               if (close_row) begin
                  st         <= ST_IDLE;
                  dram_ras_n <= 1'b1;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/fpdram_ctrl_chk.sv
module fpdram_ctrl_chk
   import fpdram_pkg::*;
#(
   parameter int CLK_NS  = 4,
   parameter int T_RC_NS = 110,
   parameter int T_PC_NS = 35
) (
   input logic clk,
   input logic rst_n,
   input logic dram_ras_n,
   input logic dram_cas_n,
   input logic dram_we_n,
   input logic dram_oe_n,
   input logic dram_dq_oe,
   input logic rsp_valid
);
   localparam int RC_C = ns_to_cyc(T_RC_NS, CLK_NS);
   localparam int PC_C = ns_to_cyc(T_PC_NS, CLK_NS);

   logic        prev_ras, prev_cas;
   logic [15:0] since_ras, since_cas;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_ras  <= 1'b1;
         prev_cas  <= 1'b1;
         since_ras <= '1;
         since_cas <= '1;
      end else begin
         prev_ras  <= dram_ras_n;
         prev_cas  <= dram_cas_n;
         since_ras <= (prev_ras && !dram_ras_n) ? 16'd1 :
                      (since_ras == '1) ? since_ras : since_ras + 1'b1;
         since_cas <= (prev_cas && !dram_cas_n) ? 16'd1 :
                      (since_cas == '1) ? since_cas : since_cas + 1'b1;
      end
   end

   // R5
   rc_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prev_ras && !dram_ras_n) |-> (since_ras >= 16'(RC_C)));

   // R6
   pc_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prev_cas && !dram_cas_n) |-> (since_cas >= 16'(PC_C)));

   // R10
   cas_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_cas_n |-> !dram_ras_n);

   // R10
   we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!dram_we_n && !dram_oe_n));

   // R2
   drive_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dram_dq_oe |-> !dram_we_n);

   // R10
   rsp_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ($rose(dram_cas_n) && dram_we_n));
endmodule

bind fpdram_ctrl fpdram_ctrl_chk #(
   .CLK_NS  (CLK_NS),
   .T_RC_NS (T_RC_NS),
   .T_PC_NS (T_PC_NS)
) u_chk (.*);

// File: tb/tb_fpdram_ctrl.sv
`timescale 1ns/1ps
module tb_fpdram_ctrl;
   localparam int RAC_C = 15, RCD_C = 11, CAC_C = 4, RC_C = 28, PC_C = 9, RP_C = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [17:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        req_ready, rsp_valid;
   logic [7:0]  rsp_rdata;
   logic [8:0]  dram_addr;
   logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
   logic [7:0]  dram_dq_out, dram_dq_in;

   always #2 clk = ~clk;

   fpdram_ctrl dut (.*);

   // behavioural memory: 16 rows x 64 columns
   logic [7:0] mem [1024];
   logic [8:0] row_l = '0, col_l = '0;
   assign dram_dq_in = (!dram_ras_n && !dram_cas_n && !dram_oe_n && dram_we_n) ?
                       mem[{row_l[3:0], col_l[5:0]}] : 8'h00;

   int total = 0, bad = 0, cyc = 0, reads = 0;
   int nras = 0, ncas = 0, nref = 0, nrsp = 0;
   int viol_rc = 0, viol_rp = 0, viol_pc = 0, viol_oe = 0, viol_ref = 0;
   int min_cas_gap = 1000, cas_in_row = 0, row_fall_cmd = 0;
   int last_ras_fall = -1000, last_ras_rise = -1000, last_cas_fall = -1000;
   int fall_dur;
   logic [8:0] fall_row = '0, last_ref_row = '0;
   logic prev_ras = 1'b1, prev_cas = 1'b1, prev_oe = 1'b1;
   bit done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) if (rst_n) begin
      if (rsp_valid) nrsp++;
      if (prev_ras && !dram_ras_n) begin
         nras++;
         if (cyc - last_ras_fall < RC_C) viol_rc++;
         if (cyc - last_ras_rise < RP_C) viol_rp++;
         last_ras_fall = cyc;
         cas_in_row = 0;
         fall_row = dram_addr;
         row_l = dram_addr;
      end
      if (!prev_ras && dram_ras_n) begin
         last_ras_rise = cyc;
         if (cas_in_row == 0) begin
            nref++;
            fall_dur = cyc - last_ras_fall;
            if (nref > 1 && fall_row != 9'(last_ref_row + 1)) viol_ref++;
            if (fall_dur != RAC_C) viol_ref++;
            last_ref_row = fall_row;
         end
      end
      if (prev_cas && !dram_cas_n) begin
         ncas++;
         if (cas_in_row == 0 && cyc - last_ras_fall != RCD_C) viol_rc++;
         if (cyc - last_cas_fall < PC_C) viol_pc++;
         if (cas_in_row > 0 && cyc - last_cas_fall < min_cas_gap) min_cas_gap = cyc - last_cas_fall;
         cas_in_row++;
         last_cas_fall = cyc;
         col_l = dram_addr;
         if (dram_we_n) begin
            if (prev_oe) viol_oe++;
         end else begin
            if (!dram_oe_n || !dram_dq_oe) viol_oe++;
            mem[{row_l[3:0], dram_addr[5:0]}] = dram_dq_out;
         end
      end
      prev_ras = dram_ras_n;
      prev_cas = dram_cas_n;
      prev_oe  = dram_oe_n;
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_req(input bit wr, input logic [17:0] a, input logic [7:0] d, output int acc);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      acc = cyc + 1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic do_read(input logic [17:0] a, output logic [7:0] d, output int lat);
      int acc, n;
      do_req(1'b0, a, 8'h00, acc);
      reads++;
      n = 0;
      while (!rsp_valid && n < 40) begin @(negedge clk); n++; end
      lat = rsp_valid ? cyc - acc : -1;
      d = rsp_rdata;
   endtask

   function automatic logic [17:0] ad(input int r, input int c);
      return {9'(r), 9'(c)};
   endfunction

   task automatic t_reset;
      repeat (3) @(negedge clk);
      check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes high", 
            {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
      check(!dram_dq_oe && !rsp_valid, "R1 dq_oe/rsp low", {dram_dq_oe, rsp_valid}, 0);
      check(req_ready, "R1 ready", req_ready, 1);
   endtask

   task automatic t_row_read;
      logic [7:0] d; int lat;
      mem[{4'd2, 6'd7}] = 8'hC3;
      do_read(ad(2, 7), d, lat);
      check(lat == RAC_C, "R3 row-open latency", lat, RAC_C);
      check(d == 8'hC3, "R3 row-open data", d, 8'hC3);
      check(fall_row == 9'd2 && col_l == 9'd7, "R3 row/column on pins", {fall_row, col_l}, {9'd2, 9'd7});
   endtask

   task automatic t_page;
      logic [7:0] d; int lat, acc, r0;
      r0 = nras;
      do_req(1'b1, ad(2, 9), 8'h96, acc);
      repeat (8) @(negedge clk);
      check(mem[{4'd2, 6'd9}] == 8'h96, "R2 write reached memory", mem[{4'd2, 6'd9}], 8'h96);
      do_read(ad(2, 9), d, lat);
      check(d == 8'h96, "R2 read back", d, 8'h96);
      check(lat == CAC_C + 1, "R4 page latency", lat, CAC_C + 1);
      do_read(ad(2, 7), d, lat);
      check(d == 8'hC3 && lat == CAC_C + 1, "R4 second page read", lat, CAC_C + 1);
      check(nras == r0, "R4 no row reopen", nras - r0, 0);
      check(min_cas_gap == PC_C, "R6 page cycle spacing", min_cas_gap, PC_C);
   endtask

   task automatic t_miss;
      logic [7:0] d; int lat, r0;
      r0 = nras;
      mem[{4'd5, 6'd1}] = 8'h3C;
      do_read(ad(5, 1), d, lat);
      check(lat == RAC_C && d == 8'h3C, "R5 miss latency", lat, RAC_C);
      check(nras == r0 + 1, "R5 one new row access", nras - r0, 1);
      check(last_ras_rise > last_ras_fall - RC_C && last_ras_rise < last_ras_fall,
            "R5 strobe raised before reopen", last_ras_rise, last_ras_fall);
   endtask

   task automatic t_refresh;
      logic [7:0] d; int lat, n;
      mem[{4'd3, 6'd2}] = 8'h77;
      do_read(ad(3, 2), d, lat);
      n = 0;
      while (nref < 1 && n < 5000) begin @(negedge clk); n++; end
      check(nref >= 1, "R8 first refresh", nref, 1);
      do_read(ad(3, 2), d, lat);
      check(lat == RAC_C && d == 8'h77, "R9 refresh closed row", lat, RAC_C);
      n = 0;
      while (nref < 2 && n < 5000) begin @(negedge clk); n++; end
      check(nref >= 2, "R8 second refresh", nref, 2);
      check(viol_ref == 0, "R8 refresh row/duration", viol_ref, 0);
   endtask

   task automatic t_final;
      check(viol_rc == 0 && viol_rp == 0, "R5 row cycle/precharge", viol_rc + viol_rp, 0);
      check(viol_pc == 0, "R6 page spacing", viol_pc, 0);
      check(viol_oe == 0, "R7 output enable order", viol_oe, 0);
      check(nrsp == reads, "R10 one response per read", nrsp, reads);
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_row_read;
      t_page;
      t_miss;
      t_refresh;
      t_final;
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule